// File: doc/BRIEF.md
# Link Backpressure Controller

This block holds both ends of the flow-control loop on a single router-to-router link. The upstream half decides whether a flit may leave this cycle and turns a raw send request into a qualified flit-valid. The downstream half counts how many flits sit in the receiving buffer and reports back, either as one pulse per freed slot or as a single permission level. The report reaches the upstream half after a fixed number of register stages. A parameter chosen at build time selects the signalling scheme. Only the selected scheme's logic is instantiated.

In credit mode the upstream half starts with one token per receive slot. It spends a token on each flit it sends and regains one each time a returned pulse arrives. In on/off mode the receiver compares its fill level against two thresholds derived from the buffer depth, the return latency and a hysteresis margin. It withdraws permission near the top of the buffer and grants it again only after the level has dropped by the margin. The off threshold leaves exactly enough room for the flits that can still be launched while the "stop" travels back, so the buffer never overflows in either mode.

Top module: `link_bp_ctrl`

## Requirements
- R1: After reset the token count equals DEPTH, the receive occupancy is 0, can_send_o is 1 and onoff_o is 1 in both modes.
- R2: In credit mode each accepted flit uses one token. can_send_o is 0 exactly while the token count is 0.
- R3: In credit mode, a dequeue from a non-empty buffer raises credit_ret_o in the same cycle. The token it returns is added at the clock edge RET_LAT+1 edges after that cycle.
- R4: A flit accepted in the same cycle that a returned token arrives leaves the token count unchanged.
- R5: A dequeue request while the occupancy is 0 is ignored: no credit pulse, and the occupancy stays 0.
- R6: flit_vld_o is send_i AND can_send_o. A request made while can_send_o is 0 is dropped and does not add to the occupancy.
- R7: In on/off mode, onoff_o (1 = permit) becomes 0 at the edge where the occupancy reaches OFF_TH = DEPTH - RET_LAT or more. It becomes 1 where the occupancy falls to ON_TH = OFF_TH - HYST or less, and holds its value in between.
- R8: In on/off mode, can_send_o follows onoff_o delayed by RET_LAT cycles. In both modes occ_o never exceeds DEPTH.
- R9: credit_ret_o stays 0 in on/off mode, and onoff_o stays 1 in credit mode.
- R10: occ_o gives the receive occupancy. It rises by one per accepted flit and falls by one per effective dequeue, so both in one cycle leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_i | input | 1 | Upstream wishes to launch a flit |
| deq_i | input | 1 | Downstream buffer releases its oldest flit |
| can_send_o | output | 1 | Upstream permission to launch this cycle |
| flit_vld_o | output | 1 | Qualified flit launch onto the link |
| credit_ret_o | output | 1 | Credit pulse leaving the receiver (credit mode) |
| onoff_o | output | 1 | Receiver permission level, 1 = permit (on/off mode) |
| occ_o | output | $clog2(DEPTH+1) | Receive buffer occupancy |

## Verification
The bench targets the cycle in which a returned token lands while the last token is being spent. A design that counted the two events in the wrong order would block the next flit, or would let the count go past the buffer depth. It fills the buffer until sends are refused, to catch a block that stops one flit too early or too late, or that counts refused flits as stored. It issues dequeues on an empty buffer, which a faulty design turns into bogus credits or an occupancy that wraps. In on/off mode it drives the fill level through both thresholds in each direction, to expose a missing hysteresis band or an off point that lets the in-flight flits overflow the buffer.

// File: rtl/link_bp_pkg.sv
package link_bp_pkg;

   typedef enum logic {
      FC_CREDIT = 1'b0,
      FC_ONOFF  = 1'b1
   } fc_mode_e;

   function automatic int bp_cnt_w(input int depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/bp_ret_delay.sv
module bp_ret_delay #(
   parameter int   LAT     = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (LAT == 0) begin : g_wire
         assign q_o = d_i;
      end else begin : g_pipe
         logic [LAT-1:0] stage_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stage_q <= {LAT{RST_VAL}};
            end else begin
               stage_q[0] <= d_i;
               for (int i = 1; i < LAT; i++) begin
                  stage_q[i] <= stage_q[i-1];
               end
            end
         end
         assign q_o = stage_q[LAT-1];
      end
   endgenerate

endmodule

// File: rtl/bp_rx_side.sv
module bp_rx_side
   import link_bp_pkg::*;
#(
   parameter fc_mode_e MODE   = FC_CREDIT,
   parameter int       DEPTH  = 8,
   parameter int       OFF_TH = 6,
   parameter int       ON_TH  = 4,
   parameter int       CNT_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enq_i,
   input  logic             deq_i,
   output logic [CNT_W-1:0] occ_o,
   output logic             credit_o,
   output logic             on_o
);

   localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] OFF_V   = CNT_W'(OFF_TH);
   localparam logic [CNT_W-1:0] ON_V    = CNT_W'(ON_TH);

   logic [CNT_W-1:0] occ_q;
   logic [CNT_W-1:0] occ_nxt;
   logic             deq_ok;

   assign deq_ok  = deq_i && (occ_q != '0);
   assign occ_nxt = occ_q + {{(CNT_W-1){1'b0}}, enq_i} - {{(CNT_W-1){1'b0}}, deq_ok};

   always_ff @(posedge clk) begin
      if (!rst_n) occ_q <= '0;
      else        occ_q <= occ_nxt;
   end

   assign occ_o = occ_q;

   AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= DEPTH_V); // R8
   AST_DEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_i && !enq_i && occ_q != '0) |=> (occ_q == $past(occ_q) - 1'b1)); // R10
   AST_EMPTY_DEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_i && !enq_i && occ_q == '0) |=> (occ_q == '0)); // R5

   generate
      if (MODE == FC_ONOFF) begin : g_onoff
         logic on_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                on_q <= 1'b1;
            else if (occ_nxt >= OFF_V) on_q <= 1'b0;
            else if (occ_nxt <= ON_V)  on_q <= 1'b1;
         end
         assign on_o     = on_q;
         assign credit_o = 1'b0;

         AST_OFF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(on_q) |-> (occ_q >= OFF_V)); // R7
         AST_ON_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(on_q) |-> (occ_q <= ON_V)); // R7
         AST_HOLD_BAND: assert property (@(posedge clk) disable iff (!rst_n)
            (occ_q > ON_V && occ_q < OFF_V && $past(occ_q) > ON_V && $past(occ_q) < OFF_V)
            |-> $stable(on_q)); // R7
      end else begin : g_credit
         assign on_o     = 1'b1;
         assign credit_o = deq_ok;
      end
   endgenerate

endmodule

// File: rtl/bp_tx_side.sv
module bp_tx_side
   import link_bp_pkg::*;
#(
   parameter fc_mode_e MODE    = FC_CREDIT,
   parameter int       DEPTH   = 8,
   parameter int       RET_LAT = 2,
   parameter int       CNT_W   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic send_i,
   input  logic ret_raw_i,
   output logic can_send_o,
   output logic flit_vld_o
);

   localparam logic RST_RET = (MODE == FC_ONOFF) ? 1'b1 : 1'b0;

   logic ret_dly;

   bp_ret_delay #(
      .LAT     (RET_LAT),
      .RST_VAL (RST_RET)
   ) u_ret_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ret_raw_i),
      .q_o   (ret_dly)
   );

   generate
      if (MODE == FC_CREDIT) begin : g_credit
         localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);
         logic [CNT_W-1:0] tok_q;
         logic             fire;

         assign can_send_o = (tok_q != '0);
         assign fire       = send_i && can_send_o;
         assign flit_vld_o = fire;

         always_ff @(posedge clk) begin
            if (!rst_n) tok_q <= DEPTH_V;
            else        tok_q <= tok_q - {{(CNT_W-1){1'b0}}, fire}
                                       + {{(CNT_W-1){1'b0}}, ret_dly};
         end

         AST_TOK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            tok_q <= DEPTH_V); // R2
         AST_TOK_SPEND: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && !ret_dly) |=> (tok_q == $past(tok_q) - 1'b1)); // R2
         AST_TOK_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && ret_dly) |=> $stable(tok_q)); // R4
      end else begin : g_onoff
         assign can_send_o = ret_dly;
         assign flit_vld_o = send_i && ret_dly;
      end
   endgenerate

endmodule

// File: rtl/link_bp_ctrl.sv
module link_bp_ctrl
   import link_bp_pkg::*;
#(
   parameter fc_mode_e MODE    = FC_CREDIT,
   parameter int       DEPTH   = 8,
   parameter int       RET_LAT = 2,
   parameter int       HYST    = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       send_i,
   input  logic                       deq_i,
   output logic                       can_send_o,
   output logic                       flit_vld_o,
   output logic                       credit_ret_o,
   output logic                       onoff_o,
   output logic [$clog2(DEPTH+1)-1:0] occ_o
);

   localparam int CNT_W  = bp_cnt_w(DEPTH);
   localparam int OFF_TH = DEPTH - RET_LAT;
   localparam int ON_TH  = OFF_TH - HYST;

   initial begin
      if (DEPTH < 2)                 $error("link_bp_ctrl: DEPTH must be at least 2");
      if (RET_LAT < 0)               $error("link_bp_ctrl: RET_LAT must not be negative");
      if (HYST < 1)                  $error("link_bp_ctrl: HYST must be at least 1");
      if (DEPTH <= RET_LAT + HYST)   $error("link_bp_ctrl: DEPTH too small for RET_LAT and HYST");
   end

   logic vld;
   logic credit_w;
   logic on_w;
   logic ret_raw;

   bp_rx_side #(
      .MODE   (MODE),
      .DEPTH  (DEPTH),
      .OFF_TH (OFF_TH),
      .ON_TH  (ON_TH),
      .CNT_W  (CNT_W)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .enq_i    (vld),
      .deq_i    (deq_i),
      .occ_o    (occ_o),
      .credit_o (credit_w),
      .on_o     (on_w)
   );

   generate
      if (MODE == FC_CREDIT) begin : g_ret_credit
         assign ret_raw = credit_w;
      end else begin : g_ret_onoff
         assign ret_raw = on_w;
      end
   endgenerate

   bp_tx_side #(
      .MODE    (MODE),
      .DEPTH   (DEPTH),
      .RET_LAT (RET_LAT),
      .CNT_W   (CNT_W)
   ) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .send_i     (send_i),
      .ret_raw_i  (ret_raw),
      .can_send_o (can_send_o),
      .flit_vld_o (vld)
   );

   assign flit_vld_o   = vld;
   assign credit_ret_o = credit_w;
   assign onoff_o      = on_w;

   AST_GATED_SEND: assert property (@(posedge clk) disable iff (!rst_n)
      (send_i && !can_send_o) |=> (occ_o <= $past(occ_o))); // R6

endmodule

// File: tb/link_bp_ctrl_tb.sv
module link_bp_ctrl_tb;
   import link_bp_pkg::*;

   localparam int DEPTH = 8;
   localparam int LAT   = 2;
   localparam int HYST  = 2;
   localparam int OFFT  = DEPTH - LAT;
   localparam int ONT   = OFFT - HYST;
   localparam int W     = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic send = 1'b0;
   logic deq = 1'b0;

   logic         c_can, c_vld, c_cret, c_on;
   logic [W-1:0] c_occ;
   logic         o_can, o_vld, o_cret, o_on;
   logic [W-1:0] o_occ;

   always #5 clk = ~clk;

   link_bp_ctrl #(.MODE(FC_CREDIT), .DEPTH(DEPTH), .RET_LAT(LAT), .HYST(HYST)) u_dut (
      .clk(clk), .rst_n(rst_n), .send_i(send), .deq_i(deq),
      .can_send_o(c_can), .flit_vld_o(c_vld), .credit_ret_o(c_cret),
      .onoff_o(c_on), .occ_o(c_occ));

   link_bp_ctrl #(.MODE(FC_ONOFF), .DEPTH(DEPTH), .RET_LAT(LAT), .HYST(HYST)) u_dut_oo (
      .clk(clk), .rst_n(rst_n), .send_i(send), .deq_i(deq),
      .can_send_o(o_can), .flit_vld_o(o_vld), .credit_ret_o(o_cret),
      .onoff_o(o_on), .occ_o(o_occ));

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   // reference state derived from the requirements
   int m_tok, m_cocc;
   int m_oocc;
   bit m_obit;
   bit m_cp [LAT];
   bit m_op [LAT];

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit next_bit(input bit cur, input int occ_n);
      if (occ_n >= OFFT) return 1'b0;
      if (occ_n <= ONT)  return 1'b1;
      return cur;
   endfunction

   task automatic model_reset();
      m_tok = DEPTH; m_cocc = 0; m_oocc = 0; m_obit = 1'b1;
      for (int i = 0; i < LAT; i++) begin
         m_cp[i] = 1'b0;
         m_op[i] = 1'b1;
      end
   endtask

   task automatic cyc(input bit s, input bit d);
      bit ec_can, ec_vld, ec_ok, eo_can, eo_vld, eo_ok;
      int on_n;
      send = s; deq = d;
      #1;
      ec_can = (m_tok != 0);
      ec_vld = s && ec_can;
      ec_ok  = d && (m_cocc > 0);
      eo_can = m_op[LAT-1];
      eo_vld = s && eo_can;
      eo_ok  = d && (m_oocc > 0);
      chk("R2 credit can_send", int'(c_can), int'(ec_can));
      chk("R6 credit flit_vld", int'(c_vld), int'(ec_vld));
      chk("R3 R5 credit_ret pulse", int'(c_cret), int'(ec_ok));
      chk("R9 onoff_o idle in credit mode", int'(c_on), 1);
      chk("R10 credit occupancy", int'(c_occ), m_cocc);
      chk("R8 on/off can_send delayed", int'(o_can), int'(eo_can));
      chk("R6 on/off flit_vld", int'(o_vld), int'(eo_vld));
      chk("R9 credit_ret idle in on/off mode", int'(o_cret), 0);
      chk("R7 on/off level", int'(o_on), int'(m_obit));
      chk("R10 on/off occupancy", int'(o_occ), m_oocc);
      chk("R8 occupancy bound", int'(o_occ <= W'(DEPTH) && c_occ <= W'(DEPTH)), 1);
      @(posedge clk);
      m_tok = m_tok - int'(ec_vld) + int'(m_cp[LAT-1]);
      for (int i = LAT - 1; i > 0; i--) m_cp[i] = m_cp[i-1];
      m_cp[0] = ec_ok;
      m_cocc = m_cocc + int'(ec_vld) - int'(ec_ok);
      on_n = m_oocc + int'(eo_vld) - int'(eo_ok);
      for (int i = LAT - 1; i > 0; i--) m_op[i] = m_op[i-1];
      m_op[0] = m_obit;
      m_obit = next_bit(m_obit, on_n);
      m_oocc = on_n;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20241));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 credit can_send after reset", int'(c_can), 1);
      chk("R1 on/off can_send after reset", int'(o_can), 1);
      chk("R1 credit occupancy after reset", int'(c_occ), 0);
      chk("R1 on/off occupancy after reset", int'(o_occ), 0);
      chk("R1 onoff level after reset", int'(o_on), 1);
      chk("R1 credit-mode onoff after reset", int'(c_on), 1);

      // R5: dequeue on an empty buffer
      cyc(1'b0, 1'b1);
      cyc(1'b0, 1'b1);
      chk("R5 occupancy stays zero", int'(c_occ), 0);

      // R4: token arrival coincides with spending the last token
      for (int i = 0; i < DEPTH - 1; i++) cyc(1'b1, 1'b0);
      cyc(1'b0, 1'b1);
      cyc(1'b0, 1'b0);
      cyc(1'b1, 1'b0);
      chk("R4 count unchanged, still permitted", int'(c_can), 1);
      cyc(1'b1, 1'b0);
      chk("R2 last token spent blocks", int'(c_can), 0);

      // R6 R8: flood, refused requests must not be stored
      for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0);
      chk("R6 credit buffer full, not beyond", int'(c_occ), DEPTH);
      chk("R8 on/off flood stays within depth", int'(o_occ <= W'(DEPTH)), 1);
      chk("R7 on/off withdrawn when full", int'(o_on), 0);

      // R7: drain through the hysteresis band
      for (int i = 0; i < DEPTH + 2; i++) cyc(1'b0, 1'b1);
      chk("R7 permit restored after drain", int'(o_on), 1);
      chk("R3 all tokens back", int'(c_can), 1);

      // R10: simultaneous enqueue and dequeue
      cyc(1'b1, 1'b0);
      cyc(1'b1, 1'b1);
      chk("R10 enq+deq keeps occupancy", int'(c_occ), 1);

      // random phases with varying pressure
      for (int ph = 0; ph < 12; ph++) begin
         int sp = (ph % 3 == 0) ? 90 : ((ph % 3 == 1) ? 50 : 20);
         int dp = (ph % 4 == 0) ? 20 : ((ph % 4 == 1) ? 60 : 85);
         for (int k = 0; k < 250; k++) begin
            cyc(($urandom % 100) < sp, ($urandom % 100) < dp);
         end
      end

      send = 1'b0; deq = 1'b0;
      finish_run();
   end

endmodule